// File: doc/BRIEF.md
# Compressed-Stream Sync and Non-Audio Detector

This block sits behind an S/PDIF receiver. It checks the recovered payload for signs that it is not playable linear PCM. The first source is the sample-word stream: the block searches it for the burst preamble that marks a compressed bitstream. The second source is the channel-status stream: the block reads the bit that flags a non-PCM stream. From these it keeps two flags, `pcmN` and `audioN`, and their OR, `nonAudio`.

A change in either flag raises a sticky, active-low interrupt. Each flag has its own mask for the interrupt. While the DAC path is fed from the receiver, the block drives a mute request whenever `nonAudio` is set. Masking a flag only silences its interrupt. The mute request always follows the flag. Biphase decoding, clock recovery and the soft-mute ramp are handled elsewhere.

Top module: `nonaudio_sync_detect`

## Requirements
- R1: A preamble is six valid words in a row: four words of 16'h0000, then 16'hF872, then 16'h4E1F. After such a run, `pcmN` reads 1 in the cycle after the 16'h4E1F word is accepted.
- R2: The search restarts in three cases: fewer than four zero words come before 16'hF872, or the word after 16'hF872 is not 16'h4E1F, or a non-zero word breaks the zero run. Any of these leaves `pcmN` unchanged. A zero word in any position, including the slot where 16'h4E1F was expected, counts toward a new zero run. More than four leading zeros still match.
- R3: Once 4096 consecutive valid words pass with no complete preamble, `pcmN` returns to 0 in the cycle after the 4096th word. A fresh preamble restarts that count.
- R4: `audioN` takes channel-status bit 1 of a block. Frame 0 of a block is the `csValid` frame that has `blockStart` high, and frame 1 is the next `csValid` frame. The captured value is applied only at the following block start, in the cycle after that frame. Bits in other frame positions have no effect.
- R5: `nonAudio` equals `pcmN` OR `audioN`.
- R6: `muteReq` is 1 exactly when `srcSelRx` is 1 and `nonAudio` is 1, and it follows `srcSelRx` in the same cycle.
- R7: When an unmasked flag changes value, `intN` goes low in the same cycle as the flag. A flag update that leaves the value unchanged raises nothing.
- R8: While `maskPcm` or `maskAudio` is 1, a change of the matching flag does not lower `intN`. The flag and `muteReq` still change.
- R9: Once low, `intN` stays low until a one-cycle `intClear` pulse sets it high in the following cycle. If a new unmasked change arrives in the same cycle as the clear, `intN` stays low.
- R10: After reset, `pcmN`, `audioN`, `nonAudio` and `muteReq` are 0, `intN` is 1, and the preamble search is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Strobe marking a valid payload word |
| sampleWord | input | 16 | Recovered 16-bit payload word |
| csValid | input | 1 | Strobe marking one channel-status bit per frame |
| csBit | input | 1 | Channel-status bit of the current frame |
| blockStart | input | 1 | High with the frame-0 `csValid` of each status block |
| srcSelRx | input | 1 | 1 when the DAC path is fed from the receiver |
| maskPcm | input | 1 | Stops `pcmN` changes from raising the interrupt |
| maskAudio | input | 1 | Stops `audioN` changes from raising the interrupt |
| intClear | input | 1 | One-cycle pulse that releases the interrupt |
| pcmN | output | 1 | Burst preamble detected |
| audioN | output | 1 | Channel status reports non-PCM |
| nonAudio | output | 1 | OR of the two flags |
| intN | output | 1 | Sticky active-low interrupt |
| muteReq | output | 1 | Mute request to the DAC path |

## Verification
The matcher gets several word runs. One has only three zeros before 16'hF872, which shows the zero count is enforced. One has a wrong word in the 16'h4E1F slot, which shows a near miss is rejected. One has a zero in that slot followed by three more zeros and a good tail, which shows a restart is credited. One has six leading zeros, which shows a longer zero run is accepted. A run of 4096 filler words is checked one word short of expiry and then at expiry, which pins the timeout boundary. The channel-status blocks put a 1 in frame 1 and, separately, in frame 2. Checks before and after each block boundary show both the bit position and the boundary timing. The mask, source-select and clear-collision cases are each tried against both a masked and an unmasked flag change.

// File: rtl/nad_pkg.sv
package nad_pkg;
  localparam int          WORD_W  = 16;
  localparam logic [15:0] PA_CODE = 16'hF872;
  localparam logic [15:0] PB_CODE = 16'h4E1F;

  // Strobes from the control side to the flag datapath
  typedef struct packed {
    logic preambleHit;   // full burst preamble accepted this cycle
    logic silenceExpire; // timeout window ran out without a preamble
    logic csUpdate;      // block boundary with a captured status bit
    logic csValue;       // captured status bit to apply
  } nadStrobe_t;
endpackage

// File: rtl/nad_ctrl.sv
module nad_ctrl
  import nad_pkg::*;
#(
  parameter int                WORD_W        = 16,
  parameter int                ZERO_WORDS    = 4,
  parameter int                SILENCE_WORDS = 4096,
  parameter int                BLOCK_FRAMES  = 192,
  parameter int                CS_BIT_POS    = 1,
  parameter logic [WORD_W-1:0] PA            = WORD_W'(PA_CODE),
  parameter logic [WORD_W-1:0] PB            = WORD_W'(PB_CODE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic              csValid,
  input  logic              csBit,
  input  logic              blockStart,
  output nadStrobe_t        strobes
);
  localparam int             ZW           = $clog2(ZERO_WORDS + 1);
  localparam logic [ZW-1:0]  ZERO_FULL    = ZW'(ZERO_WORDS);
  localparam int             SW           = $clog2(SILENCE_WORDS);
  localparam logic [SW-1:0]  SILENCE_LAST = SW'(SILENCE_WORDS - 1);
  localparam int             FW           = $clog2(BLOCK_FRAMES + 1);
  localparam logic [FW-1:0]  FRAME_MAX    = FW'(BLOCK_FRAMES);
  localparam logic [FW-1:0]  FRAME_POS    = FW'(CS_BIT_POS);

  // preamble matcher state
  logic [ZW-1:0] zeroRun;
  logic          paSeen;
  // silence window
  logic [SW-1:0] silenceCnt;
  // channel-status capture
  logic [FW-1:0] frameIdx;
  logic          capBit;
  logic          bitHeld;

  logic          isZero, isPa, isPb;
  logic          hitNow, expireNow;
  logic [FW-1:0] curIdx;
  logic          captureNow, updateNow;

  always_comb begin
    isZero     = (sampleWord == '0);
    isPa       = (sampleWord == PA);
    isPb       = (sampleWord == PB);
    hitNow     = sampleValid && paSeen && isPb;
    expireNow  = sampleValid && !hitNow && (silenceCnt == SILENCE_LAST);
    curIdx     = blockStart ? '0 : frameIdx;
    captureNow = csValid && (curIdx == FRAME_POS);
    updateNow  = csValid && blockStart && bitHeld;
  end

  // Zero-run counter saturates at ZERO_WORDS, so longer zero runs still match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun <= '0;
      paSeen  <= 1'b0;
    end else if (sampleValid) begin
      if (paSeen) begin
        paSeen  <= 1'b0;
        zeroRun <= isZero ? ZW'(1) : '0;
      end else if (isZero) begin
        if (zeroRun != ZERO_FULL) zeroRun <= zeroRun + ZW'(1);
      end else if (isPa && (zeroRun == ZERO_FULL)) begin
        paSeen  <= 1'b1;
        zeroRun <= '0;
      end else begin
        zeroRun <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      silenceCnt <= '0;
    end else if (sampleValid) begin
      if (hitNow || expireNow) silenceCnt <= '0;
      else                     silenceCnt <= silenceCnt + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameIdx <= '0;
      capBit   <= 1'b0;
      bitHeld  <= 1'b0;
    end else if (csValid) begin
      frameIdx <= (curIdx == FRAME_MAX) ? curIdx : curIdx + FW'(1);
      if (captureNow) capBit <= csBit;
      if (captureNow)     bitHeld <= 1'b1;
      else if (updateNow) bitHeld <= 1'b0;
    end
  end

  assign strobes.preambleHit   = hitNow;
  assign strobes.silenceExpire = expireNow;
  assign strobes.csUpdate      = updateNow;
  assign strobes.csValue       = capBit;
endmodule

// File: rtl/nad_flags.sv
module nad_flags
  import nad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  nadStrobe_t strobes,
  input  logic       srcSelRx,
  input  logic       maskPcm,
  input  logic       maskAudio,
  input  logic       intClear,
  output logic       pcmN,
  output logic       audioN,
  output logic       nonAudio,
  output logic       intN,
  output logic       muteReq
);
  logic pcmFlag, audioFlag, intPend;
  logic pcmNext, audioNext, pcmEvt, audioEvt, intNext;

  always_comb begin
    if (strobes.preambleHit)        pcmNext = 1'b1;
    else if (strobes.silenceExpire) pcmNext = 1'b0;
    else                            pcmNext = pcmFlag;
    audioNext = strobes.csUpdate ? strobes.csValue : audioFlag;
    pcmEvt    = (pcmNext != pcmFlag) && !maskPcm;
    audioEvt  = (audioNext != audioFlag) && !maskAudio;
    // A fresh event outranks a clear in the same cycle
    if (pcmEvt || audioEvt) intNext = 1'b1;
    else if (intClear)      intNext = 1'b0;
    else                    intNext = intPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcmFlag   <= 1'b0;
      audioFlag <= 1'b0;
      intPend   <= 1'b0;
    end else begin
      pcmFlag   <= pcmNext;
      audioFlag <= audioNext;
      intPend   <= intNext;
    end
  end

  assign pcmN     = pcmFlag;
  assign audioN   = audioFlag;
  assign nonAudio = pcmFlag | audioFlag;
  assign intN     = ~intPend;
  assign muteReq  = srcSelRx & (pcmFlag | audioFlag);
endmodule

// File: rtl/nonaudio_sync_detect.sv
module nonaudio_sync_detect
  import nad_pkg::*;
#(
  parameter int                WORD_W        = 16,
  parameter int                ZERO_WORDS    = 4,
  parameter int                SILENCE_WORDS = 4096,
  parameter int                BLOCK_FRAMES  = 192,
  parameter int                CS_BIT_POS    = 1,
  parameter logic [WORD_W-1:0] PA            = WORD_W'(PA_CODE),
  parameter logic [WORD_W-1:0] PB            = WORD_W'(PB_CODE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic              csValid,
  input  logic              csBit,
  input  logic              blockStart,
  input  logic              srcSelRx,
  input  logic              maskPcm,
  input  logic              maskAudio,
  input  logic              intClear,
  output logic              pcmN,
  output logic              audioN,
  output logic              nonAudio,
  output logic              intN,
  output logic              muteReq
);
  nadStrobe_t strobes;

  nad_ctrl #(
    .WORD_W(WORD_W), .ZERO_WORDS(ZERO_WORDS), .SILENCE_WORDS(SILENCE_WORDS),
    .BLOCK_FRAMES(BLOCK_FRAMES), .CS_BIT_POS(CS_BIT_POS), .PA(PA), .PB(PB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleWord(sampleWord),
    .csValid(csValid), .csBit(csBit), .blockStart(blockStart), .strobes(strobes)
  );

  nad_flags u_flags (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcSelRx(srcSelRx),
    .maskPcm(maskPcm), .maskAudio(maskAudio), .intClear(intClear),
    .pcmN(pcmN), .audioN(audioN), .nonAudio(nonAudio), .intN(intN), .muteReq(muteReq)
  );
endmodule

// File: rtl/nad_checker.sv
module nad_checker #(
  parameter int                WORD_W = 16,
  parameter logic [WORD_W-1:0] PB     = WORD_W'(nad_pkg::PB_CODE)
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [WORD_W-1:0] sampleWord,
  input logic              csValid,
  input logic              csBit,
  input logic              blockStart,
  input logic              srcSelRx,
  input logic              maskPcm,
  input logic              maskAudio,
  input logic              intClear,
  input logic              pcmN,
  input logic              audioN,
  input logic              nonAudio,
  input logic              intN,
  input logic              muteReq
);
  p_pcm_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pcmN) |-> $past(sampleValid && (sampleWord == PB)));

  p_pcm_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pcmN) |-> $past(sampleValid));

  p_audio_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(csValid && blockStart) |-> $stable(audioN));

  p_nonaudio_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nonAudio) |-> ($rose(pcmN) || $rose(audioN)));

  p_mute_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    muteReq |-> (srcSelRx && nonAudio));

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskPcm && maskAudio && intN) |=> intN);

  p_int_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && !intClear) |=> !intN);
endmodule

bind nonaudio_sync_detect nad_checker #(.WORD_W(WORD_W), .PB(PB)) u_chk (.*);

// File: tb/nonaudio_sync_detect_test.sv
module nonaudio_sync_detect_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleWord = '0;
  logic        csValid = 1'b0, csBit = 1'b0, blockStart = 1'b0;
  logic        srcSelRx = 1'b1, maskPcm = 1'b0, maskAudio = 1'b0, intClear = 1'b0;
  logic        pcmN, audioN, nonAudio, intN, muteReq;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;

  typedef struct {
    int    due;
    logic  pcm, aud, irqN, mute;
    string tag;
  } expItem_t;
  expItem_t sb[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  nonaudio_sync_detect uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleWord(sampleWord),
    .csValid(csValid), .csBit(csBit), .blockStart(blockStart), .srcSelRx(srcSelRx),
    .maskPcm(maskPcm), .maskAudio(maskAudio), .intClear(intClear),
    .pcmN(pcmN), .audioN(audioN), .nonAudio(nonAudio), .intN(intN), .muteReq(muteReq)
  );

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input expItem_t e);
    checkBit(e.tag, "pcmN", pcmN, e.pcm);
    checkBit(e.tag, "audioN", audioN, e.aud);
    checkBit(e.tag, "nonAudio", nonAudio, e.pcm | e.aud);
    checkBit(e.tag, "intN", intN, e.irqN);
    checkBit(e.tag, "muteReq", muteReq, e.mute);
  endtask

  // monitor: pops expectations when their cycle has come
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      expItem_t e;
      e = sb.pop_front();
      compareAll(e);
    end
  end

  // driver side
  task automatic expectNext(input logic p, input logic a, input logic i, input logic m, input string tag);
    expItem_t e;
    e.due = cyc + 1; e.pcm = p; e.aud = a; e.irqN = i; e.mute = m; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk); #2;
    sampleValid = 1'b0; csValid = 1'b0; blockStart = 1'b0; intClear = 1'b0; csBit = 1'b0;
  endtask

  task automatic setWord(input logic [15:0] w);
    sampleValid = 1'b1; sampleWord = w;
  endtask

  task automatic word(input logic [15:0] w);
    setWord(w); tick();
  endtask

  task automatic zeros(input int n);
    for (int k = 0; k < n; k++) word(16'h0000);
  endtask

  task automatic setFrame(input logic b, input logic start);
    csValid = 1'b1; csBit = b; blockStart = start;
  endtask

  task automatic frame(input logic b, input logic start);
    setFrame(b, start); tick();
  endtask

  task automatic clearInt(input logic p, input logic a, input logic m, input string tag);
    intClear = 1'b1; expectNext(p, a, 1'b1, m, tag); tick();
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    begin
      expItem_t e;
      e.due = 0; e.pcm = 0; e.aud = 0; e.irqN = 1; e.mute = 0; e.tag = "R10 reset";
      compareAll(e);
    end
    rstN = 1'b1;
    tick();
    begin
      expItem_t e;
      e.due = 0; e.pcm = 0; e.aud = 0; e.irqN = 1; e.mute = 0; e.tag = "R10 after release";
      compareAll(e);
    end

    // R2: only three zeros before Pa
    zeros(3); word(16'hF872); setWord(16'h4E1F);
    expectNext(0, 0, 1, 0, "R2 three zeros"); tick();
    // R2: wrong Pb
    zeros(4); word(16'hF872); setWord(16'h1234);
    expectNext(0, 0, 1, 0, "R2 bad Pb"); tick();
    // R2/R1: zero in Pb slot restarts the run, completes after three more
    zeros(4); word(16'hF872); word(16'h0000); zeros(3); word(16'hF872);
    setWord(16'h4E1F);
    expectNext(1, 0, 0, 1, "R1 R2 R7 restart match"); tick();
    clearInt(1, 0, 1, "R9 clear");
    sb.push_back('{cyc + 1, 1, 0, 1, 1, "R9 stays clear"}); tick();

    // R1: six zeros, no flag change -> no interrupt (R7)
    zeros(6); word(16'hF872); setWord(16'h4E1F);
    expectNext(1, 0, 1, 1, "R1 R7 long zero run, no change"); tick();

    // R3: timeout after 4096 words
    for (int k = 0; k < 4094; k++) word(16'h1111);
    setWord(16'h1111); expectNext(1, 0, 1, 1, "R3 one short of expiry"); tick();
    setWord(16'h1111); expectNext(0, 0, 0, 0, "R3 expiry"); tick();
    clearInt(0, 0, 0, "R9 clear after expiry");

    // R4: block 1 carries bit 1 = 1
    frame(0, 1); frame(1, 0); frame(0, 0); frame(0, 0);
    setFrame(0, 0); expectNext(0, 0, 1, 0, "R4 no mid-block update"); tick();
    setFrame(0, 1); expectNext(0, 1, 0, 1, "R4 R5 R6 R7 boundary update"); tick();
    clearInt(0, 1, 1, "R9 clear");
    // block 2: only frame 2 set -> audioN drops at next boundary
    frame(0, 0); frame(1, 0); frame(0, 0);
    setFrame(0, 1); expectNext(0, 0, 0, 0, "R4 frame-2 bit ignored"); tick();
    clearInt(0, 0, 0, "R9 clear");

    // R8: mask audio, block 3 has bit 1 set
    maskAudio = 1'b1;
    frame(1, 0); frame(0, 0);
    setFrame(0, 1); expectNext(0, 1, 1, 1, "R8 masked audio change still mutes"); tick();
    srcSelRx = 1'b0; #1;
    checkBit("R6 source off", "muteReq", muteReq, 1'b0);
    checkBit("R5 source off", "nonAudio", nonAudio, 1'b1);
    srcSelRx = 1'b1; #1;
    checkBit("R6 source on", "muteReq", muteReq, 1'b1);

    // R9: new event in the same cycle as clear
    zeros(4); word(16'hF872); setWord(16'h4E1F); intClear = 1'b1;
    expectNext(1, 1, 0, 1, "R9 event beats clear"); tick();
    clearInt(1, 1, 1, "R9 clear");

    // R8: masked pcm expiry
    maskPcm = 1'b1;
    for (int k = 0; k < 4095; k++) word(16'h2222);
    setWord(16'h2222); expectNext(0, 1, 1, 1, "R8 masked pcm expiry"); tick();
    sb.push_back('{cyc + 1, 0, 1, 1, 1, "R8 interrupt stays high"}); tick();

    repeat (2) @(posedge clk);
    #5;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule